// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This controller steers data around a five-stage integer pipeline (fetch, decode, execute, memory, writeback). It compares the register numbers held in the decode, execute, memory and writeback stages. From those comparisons it picks the source for each of the two ALU operands in the execute stage and for the store data in the memory stage.

It also raises a one-cycle freeze when a forward cannot arrive in time. That case is an instruction in decode that needs, as an ALU or address operand, the result of a load that is now in execute. During the freeze the program counter and the decode latch hold their values, and a no-op is placed in the execute latch.

The block contains no datapath. It only drives multiplexer selects and the two freeze controls, which the surrounding pipeline uses.

Top module: `hzd_fwd_unit`

## Requirements
- R1: An execute-stage operand whose register matches the memory-stage destination selects code 1 (memory-stage ALU result). This applies when that instruction writes a register and is not a load.
- R2: When only a writeback-stage non-load writer matches, the operand select is code 2 (writeback ALU result).
- R3: When only a writeback-stage load matches, the operand select is code 3 (loaded data).
- R4: When the memory-stage and writeback-stage producers both match, the memory-stage result (code 1) is chosen.
- R5: Register 0 is never forwarded and never causes a freeze. Its operand select stays at code 0 (register file).
- R6: A freeze is raised when execute holds a load with a nonzero destination and decode reads that register through its first source or through a non-store second source.
- R7: The store data in the memory stage is taken from writeback when the writeback destination, if nonzero and written, equals the store's data register. The select is code 2 for loaded data and code 1 for an ALU result, and code 0 otherwise. A store whose data register is the destination of the load in execute is not frozen.
- R8: The PC/decode hold output and the execute no-op insert output are always asserted together.
- R9: A matching stage whose write enable is low is not used as a forwarding source.
- R10: An operand that matches no producer in the memory or writeback stage reads the register file (code 0).
- R11: A load in the memory stage is never a forwarding source for an execute operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the checks |
| rst_n | input | 1 | Active-low reset |
| id_rs | input | REG_W | Decode first source register |
| id_rt | input | REG_W | Decode second source register |
| id_uses_rs | input | 1 | Decode reads first source |
| id_uses_rt | input | 1 | Decode reads second source |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs | input | REG_W | Execute operand A register |
| ex_rt | input | REG_W | Execute operand B register |
| ex_rd | input | REG_W | Execute destination |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Memory-stage destination |
| mem_rt | input | REG_W | Memory-stage store data register |
| mem_wen | input | 1 | Memory-stage writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | REG_W | Writeback destination |
| wb_wen | input | 1 | Writeback writes a register |
| wb_is_load | input | 1 | Writeback instruction is a load |
| sel_a | output | 2 | Operand A select (0 RF, 1 mem ALU, 2 wb ALU, 3 wb load) |
| sel_b | output | 2 | Operand B select, same coding |
| sel_st | output | 2 | Store data select (0 keep, 1 wb ALU, 2 wb load) |
| hold_front | output | 1 | Hold PC and decode latch |
| insert_bubble | output | 1 | Load a no-op into the execute latch |

## Verification
A freeze and the forwarding selects can be active in the same cycle. For example, a load sits in execute and its dependent waits in decode, while the load's own operand is forwarded and a store in the memory stage takes its data from writeback. A directed case sets up exactly that cycle. It requires the freeze outputs and every select to show their individually expected codes. Exhaustive sweeps over four register numbers and all flag settings compare each select and the freeze against arithmetic computed in the bench.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    OP_RF  = 2'd0,
    OP_EXM = 2'd1,
    OP_WBA = 2'd2,
    OP_WBL = 2'd3
  } opsel_e;

  typedef enum logic [1:0] {
    ST_KEEP = 2'd0,
    ST_WBA  = 2'd1,
    ST_WBL  = 2'd2
  } stsel_e;

  function automatic logic reg_match(input logic [7:0] a, input logic [7:0] b);
    return (a == b) && (a != 8'd0);
  endfunction
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             mem_is_load,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  input  logic             wb_is_load,
  output opsel_e           sel,
  output logic             exm_hit,
  output logic             wb_hit
);
  localparam int PADW = 8 - REG_W;

  assign exm_hit = mem_wen && !mem_is_load &&
                   reg_match({{PADW{1'b0}}, src}, {{PADW{1'b0}}, mem_rd});
  assign wb_hit  = wb_wen &&
                   reg_match({{PADW{1'b0}}, src}, {{PADW{1'b0}}, wb_rd});

  always_comb begin
    if (exm_hit)     sel = OP_EXM;
    else if (wb_hit) sel = wb_is_load ? OP_WBL : OP_WBA;
    else             sel = OP_RF;
  end

  assert_young_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_hit && wb_hit) |-> sel == OP_EXM);
  assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> sel == OP_RF);
  assert_no_load_exm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_is_load |-> sel != OP_EXM);
endmodule

// File: rtl/hzd_store_fwd.sv
module hzd_store_fwd
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] mem_rt,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  input  logic             wb_is_load,
  output stsel_e           sel
);
  localparam int PADW = 8 - REG_W;
  logic st_hit;

  assign st_hit = mem_is_store && wb_wen &&
                  reg_match({{PADW{1'b0}}, mem_rt}, {{PADW{1'b0}}, wb_rd});

  always_comb begin
    if (st_hit) sel = wb_is_load ? ST_WBL : ST_WBA;
    else        sel = ST_KEEP;
  end

  assert_store_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != ST_KEEP) |-> mem_is_store && wb_wen);
endmodule

// File: rtl/hzd_load_interlock.sv
module hzd_load_interlock
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_uses_rs,
  input  logic             id_uses_rt,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_is_load,
  output logic             stall,
  output logic             rs_dep,
  output logic             rt_dep
);
  localparam int PADW = 8 - REG_W;

  assign rs_dep = id_uses_rs &&
                  reg_match({{PADW{1'b0}}, id_rs}, {{PADW{1'b0}}, ex_rd});
  // store data is bypassed later in the memory stage, so it does not freeze
  assign rt_dep = id_uses_rt && !id_is_store &&
                  reg_match({{PADW{1'b0}}, id_rt}, {{PADW{1'b0}}, ex_rd});
  assign stall  = ex_is_load && (rs_dep || rt_dep);

  assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ex_is_load && ex_rd != '0);
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_uses_rs,
  input  logic             id_uses_rt,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic [REG_W-1:0] mem_rt,
  input  logic             mem_wen,
  input  logic             mem_is_load,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  input  logic             wb_is_load,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [1:0]       sel_st,
  output logic             hold_front,
  output logic             insert_bubble
);
  localparam int NUM_OPS = 2;

  logic [REG_W-1:0] op_src  [NUM_OPS];
  opsel_e           op_sel  [NUM_OPS];
  logic             op_exm  [NUM_OPS];
  logic             op_wb   [NUM_OPS];
  stsel_e           st_sel;
  logic             lu_stall, lu_rs, lu_rt;

  assign op_src[0] = ex_rs;
  assign op_src[1] = ex_rt;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hzd_fwd_sel #(.REG_W(REG_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .src(op_src[g]),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
      .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_is_load(wb_is_load),
      .sel(op_sel[g]), .exm_hit(op_exm[g]), .wb_hit(op_wb[g])
    );
  end

  hzd_store_fwd #(.REG_W(REG_W)) u_st (
    .clk(clk), .rst_n(rst_n), .mem_is_store(mem_is_store), .mem_rt(mem_rt),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_is_load(wb_is_load), .sel(st_sel)
  );

  hzd_load_interlock #(.REG_W(REG_W)) u_lu (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
    .id_uses_rs(id_uses_rs), .id_uses_rt(id_uses_rt), .id_is_store(id_is_store),
    .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .stall(lu_stall), .rs_dep(lu_rs), .rt_dep(lu_rt)
  );

  assign sel_a         = op_sel[0];
  assign sel_b         = op_sel[1];
  assign sel_st        = st_sel;
  assign hold_front    = lu_stall;
  assign insert_bubble = lu_stall;

  assert_freeze_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front == insert_bubble);
  assert_dep_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && (lu_rs || lu_rt)) |-> hold_front);
  assert_wen_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wen && !wb_wen) |-> (sel_a == 2'd0 && sel_b == 2'd0 && sel_st == 2'd0));
  assert_hit_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_exm[0] |-> sel_a == 2'd1);
endmodule

// File: tb/test_hzd_fwd_unit.sv
module test_hzd_fwd_unit;
  localparam int REG_W = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [REG_W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_rt, wb_rd;
  logic id_uses_rs, id_uses_rt, id_is_store, ex_is_load;
  logic mem_wen, mem_is_load, mem_is_store, wb_wen, wb_is_load;
  logic [1:0] sel_a, sel_b, sel_st;
  logic hold_front, insert_bubble;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hzd_fwd_unit #(.REG_W(REG_W)) i_hzd_fwd_unit (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_rt, wb_rd} = '0;
    {id_uses_rs, id_uses_rt, id_is_store, ex_is_load} = '0;
    {mem_wen, mem_is_load, mem_is_store, wb_wen, wb_is_load} = '0;
  endtask

  function automatic int exp_op(int s, int mrd, int mw, int ml, int wrd, int ww, int wl);
    if (s == 0) return 0;
    if (mw == 1 && ml == 0 && mrd == s) return 1;
    if (ww == 1 && wrd == s) return 2 + wl;
    return 0;
  endfunction

  function automatic string op_tag(int s, int mrd, int mw, int ml, int wrd, int ww, int wl);
    bit mh = (mw == 1 && ml == 0 && mrd == s);
    bit wh = (ww == 1 && wrd == s);
    if (s == 0) return "R5";
    if (mw == 1 && ml == 1 && mrd == s) return "R11";
    if (mh && wh) return "R4";
    if (mh) return "R1";
    if (wh) return (wl == 1) ? "R3" : "R2";
    if (mrd == s || wrd == s) return "R9";
    return "R10";
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    // reset state: idle pipeline gives register-file selects, no freeze
    chk("R10 reset sel_a", sel_a, 0);
    chk("R10 reset sel_b", sel_b, 0);
    chk("R7 reset sel_st", sel_st, 0);
    chk("R8 reset hold", hold_front, 0);
    rst_n = 1'b1;

    // operand select sweep: both operands, src in 0..3
    for (int n = 0; n < 1024; n++) begin
      int s, mrd, wrd, mw, ml, ww, wl, e;
      string t;
      @(negedge clk);
      clear_all();
      s = n & 3; mrd = (n >> 2) & 3; wrd = (n >> 4) & 3;
      mw = (n >> 6) & 1; ml = (n >> 7) & 1; ww = (n >> 8) & 1; wl = (n >> 9) & 1;
      ex_rs = REG_W'(s); ex_rt = REG_W'(s);
      mem_rd = REG_W'(mrd); mem_wen = mw[0]; mem_is_load = ml[0];
      wb_rd = REG_W'(wrd); wb_wen = ww[0]; wb_is_load = wl[0];
      #2;
      e = exp_op(s, mrd, mw, ml, wrd, ww, wl);
      t = op_tag(s, mrd, mw, ml, wrd, ww, wl);
      chk({t, " sel_a"}, sel_a, e);
      chk({t, " sel_b"}, sel_b, e);
    end

    // load interlock sweep
    for (int n = 0; n < 1024; n++) begin
      int erd, rs, rt, urs, urt, st, ld, e;
      @(negedge clk);
      clear_all();
      erd = n & 3; rs = (n >> 2) & 3; rt = (n >> 4) & 3;
      urs = (n >> 6) & 1; urt = (n >> 7) & 1; st = (n >> 8) & 1; ld = (n >> 9) & 1;
      ex_rd = REG_W'(erd); ex_is_load = ld[0];
      id_rs = REG_W'(rs); id_rt = REG_W'(rt);
      id_uses_rs = urs[0]; id_uses_rt = urt[0]; id_is_store = st[0];
      #2;
      e = (ld == 1 && erd != 0 &&
           ((urs == 1 && rs == erd) || (urt == 1 && st == 0 && rt == erd))) ? 1 : 0;
      if (erd == 0) chk("R5 no freeze on r0", hold_front, 0);
      else if (st == 1 && urt == 1 && rt == erd && !(urs == 1 && rs == erd))
        chk("R7 store data no freeze", hold_front, e);
      else chk("R6 hold", hold_front, e);
      chk("R8 bubble", insert_bubble, e);
    end

    // store data sweep
    for (int n = 0; n < 256; n++) begin
      int mrt, wrd, ww, wl, ms, e;
      @(negedge clk);
      clear_all();
      mrt = n & 3; wrd = (n >> 2) & 3; ww = (n >> 4) & 1; wl = (n >> 5) & 1; ms = (n >> 6) & 1;
      mem_rt = REG_W'(mrt); mem_is_store = ms[0];
      wb_rd = REG_W'(wrd); wb_wen = ww[0]; wb_is_load = wl[0];
      mem_rd = REG_W'(n >> 7);
      #2;
      e = (ms == 1 && ww == 1 && mrt != 0 && mrt == wrd) ? (wl == 1 ? 2 : 1) : 0;
      chk("R7 sel_st", sel_st, e);
    end

    // coincidence: freeze plus operand and store forwarding in one cycle
    @(negedge clk);
    clear_all();
    ex_is_load = 1'b1; ex_rd = 5'd4; ex_rs = 5'd2; ex_rt = 5'd9;
    id_rs = 5'd4; id_uses_rs = 1'b1;
    mem_is_store = 1'b1; mem_rt = 5'd2;
    mem_rd = 5'd9; mem_wen = 1'b1;
    wb_rd = 5'd2; wb_wen = 1'b1; wb_is_load = 1'b1;
    #2;
    chk("R6 combined hold", hold_front, 1);
    chk("R8 combined bubble", insert_bubble, 1);
    chk("R3 combined sel_a", sel_a, 3);
    chk("R1 combined sel_b", sel_b, 1);
    chk("R7 combined sel_st", sel_st, 2);

    // after the bubble, the dependent reaches execute with the load in memory
    @(negedge clk);
    clear_all();
    ex_rs = 5'd4; mem_rd = 5'd4; mem_wen = 1'b1; mem_is_load = 1'b1;
    #2;
    chk("R11 load in mem not bypassed", sel_a, 0);
    chk("R6 no second freeze", hold_front, 0);
    @(negedge clk);
    clear_all();
    ex_rs = 5'd4; wb_rd = 5'd4; wb_wen = 1'b1; wb_is_load = 1'b1;
    #2;
    chk("R3 load data from writeback", sel_a, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule